// File: doc/BRIEF.md
# Masked GPIO Bank with Automatic Transmit/Receive Override

This block controls the general-purpose pins of one radio side. The pins form two groups of 16, a transmit-side group and a receive-side group. Each group has its own direction register (output enable) and data register. A pin drives only when its direction bit is set. When the bit is clear, the pin is treated as an input and its pad level can be read back.

Every register is updated by a single 32-bit write word. The word carries a per-bit mask and a new value, so software can change some bits without reading the register first. Each group also has an automatic transmit/receive override. The override is set up by an override-select mask and two level registers, one used while transmitting and one used while receiving. For each selected pin, the level follows a transmit-active input instead of the data register. A read strobe returns both groups' pad levels in one word after two-stage synchronisation.

Top module: `gpio_atr_bank`

## Requirements
- R1: After a cycle with `rst_n` low, every register is 0, so `tx_pad_oe`, `rx_pad_oe`, `tx_pad_o` and `rx_pad_o` are all 0.
- R2: A write changes only the bits of the addressed register whose mask bit `wr_data[31:16]` is 1. Each such bit takes the matching value bit from `wr_data[15:0]`, and every bit whose mask bit is 0 keeps its old state. The new contents are visible on the pins after the clock edge that samples `wr_en`.
- R3: The register addresses are as follows. Transmit group: 0 is the output enable and 1 is the data. Receive group: 2 is the output enable and 3 is the data. Transmit-group override: 4 is the select mask, 5 is the transmit level and 6 is the receive level. Receive-group override: 7 is the select mask, 8 is the transmit level and 9 is the receive level. A write to any other address changes no register.
- R4: Each `*_pad_oe` bit equals the matching bit of that group's output-enable register. A 1 means the pin drives and a 0 means the pin is high impedance.
- R5: A pin whose override-select bit is 0 drives the matching bit of its group's data register.
- R6: When a group's override-select mask is all zeros, the whole `*_pad_o` vector of that group equals its data register, whatever `tx_active` is.
- R7: While `tx_active` is 1, a pin whose override-select bit is 1 drives the matching bit of its group's transmit-level register.
- R8: While `tx_active` is 0, a pin whose override-select bit is 1 drives the matching bit of its group's receive-level register.
- R9: When a cycle has `rd_en` high with `rd_addr` = 10, `rd_data` shows the synchronised pad levels from the next clock edge onward. Bits 31:16 hold the receive group and bits 15:0 hold the transmit group. A pad change reaches `rd_data` only through two register stages. `rd_data` holds its value in every other cycle.
- R10: Writes to one group's registers leave the other group's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Mask in 31:16, value in 15:0 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read register address (10 = pad readback) |
| rd_data | output | 32 | Readback word, {receive pads, transmit pads} |
| tx_active | input | 1 | High while the radio side transmits |
| tx_pad_i | input | 16 | Sampled levels of the transmit-group pads |
| tx_pad_o | output | 16 | Levels driven on the transmit-group pads |
| tx_pad_oe | output | 16 | Per-pin drive enable, transmit group |
| rx_pad_i | input | 16 | Sampled levels of the receive-group pads |
| rx_pad_o | output | 16 | Levels driven on the receive-group pads |
| rx_pad_oe | output | 16 | Per-pin drive enable, receive group |

## Verification
Some properties are checked by assertions on every cycle:
- Masked writes keep the unmasked bits and load the masked bits.
- Registers stay unchanged between writes and clear on reset.
- A group with an all-zero override mask drives its data register.
- A fully overridden group follows the transmit level or the receive level, as `tx_active` selects.
- The readback word holds between read strobes.

Other behaviour is shown only by the bench's scenarios:
- Pins that mix overridden and plain bits.
- Ignored addresses.
- Independence of the two groups.
- The two-cycle pad-to-readback latency.

// File: rtl/gpio_atr_pkg.sv
// Package: shared widths, register addresses and the masked-update helper
// for the GPIO bank. Assumes one 16-bit pin group per side and a write
// word exactly twice the group width.
package gpio_atr_pkg;
    localparam int GPIO_W  = 16;
    localparam int WORD_W  = 2 * GPIO_W;
    localparam int ADDR_W  = 4;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_TX_OE   = 4'd0;
    localparam logic [ADDR_W-1:0] A_TX_OUT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_RX_OE   = 4'd2;
    localparam logic [ADDR_W-1:0] A_RX_OUT  = 4'd3;
    localparam logic [ADDR_W-1:0] A_TX_SEL  = 4'd4;
    localparam logic [ADDR_W-1:0] A_TX_ATXV = 4'd5;
    localparam logic [ADDR_W-1:0] A_TX_ARXV = 4'd6;
    localparam logic [ADDR_W-1:0] A_RX_SEL  = 4'd7;
    localparam logic [ADDR_W-1:0] A_RX_ATXV = 4'd8;
    localparam logic [ADDR_W-1:0] A_RX_ARXV = 4'd9;
    localparam logic [ADDR_W-1:0] A_PAD_RB  = 4'd10;

    // Register slots inside one pin group
    typedef enum logic [2:0] {
        SLOT_OE   = 3'd0,
        SLOT_OUT  = 3'd1,
        SLOT_SEL  = 3'd2,
        SLOT_ATXV = 3'd3,
        SLOT_ARXV = 3'd4
    } gpio_slot_e;

    localparam int N_SLOTS = 5;

    // Merge new value into old state under a bit mask
    function automatic logic [GPIO_W-1:0] masked_merge(
        input logic [GPIO_W-1:0] old_q,
        input logic [GPIO_W-1:0] mask,
        input logic [GPIO_W-1:0] val
    );
        return (old_q & ~mask) | (val & mask);
    endfunction
endpackage

// File: rtl/gpio_masked_reg.sv
// Module: one W-bit register loaded through a mask/value pair.
// Assumes the caller has already decoded the address into we.
module gpio_masked_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wval,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, otherwise merge masked bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= (q & ~wmask) | (wval & wmask);
    end

    // R1: a reset cycle leaves the register cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: bits outside the mask survive a write
    a_r2_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(rst_n)) |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));

    // R2: bits inside the mask take the written value
    a_r2_load_masked: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q & $past(wmask)) == ($past(wval) & $past(wmask))));

    // R3: without a decoded write the register holds
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/gpio_sync2.sv
// Module: two-flop synchroniser for a bus of asynchronous pad levels.
// Assumes each bit is sampled independently (no bus coherency needed).
module gpio_sync2 #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Purpose: shift the pad levels through two register stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_group.sv
// Module: one pin group. Holds direction, data, override-select and two
// override levels, and chooses the driven level per pin. Assumes the
// five addresses passed in are distinct.
module gpio_group
    import gpio_atr_pkg::*;
#(
    parameter int               W      = GPIO_W,
    parameter int               AW     = ADDR_W,
    parameter logic [AW-1:0]    A_OE   = '0,
    parameter logic [AW-1:0]    A_OUT  = '0,
    parameter logic [AW-1:0]    A_SEL  = '0,
    parameter logic [AW-1:0]    A_ATXV = '0,
    parameter logic [AW-1:0]    A_ARXV = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [2*W-1:0] wr_data,
    input  logic          tx_active,
    output logic [W-1:0]  pad_o,
    output logic [W-1:0]  pad_oe
);
    localparam logic [N_SLOTS*AW-1:0] SLOT_ADDRS = {A_ARXV, A_ATXV, A_SEL, A_OUT, A_OE};

    logic [W-1:0] wmask;
    logic [W-1:0] wval;
    logic [W-1:0] regs [N_SLOTS];
    logic [W-1:0] atr_level;

    assign wmask = wr_data[2*W-1:W];
    assign wval  = wr_data[W-1:0];

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic hit;
        // Purpose: decode this slot's write strobe
        always_comb hit = wr_en && (wr_addr == SLOT_ADDRS[s*AW +: AW]);

        gpio_masked_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (hit),
            .wmask (wmask),
            .wval  (wval),
            .q     (regs[s])
        );
    end

    // Purpose: pick the override level for the current radio direction
    always_comb atr_level = tx_active ? regs[SLOT_ATXV] : regs[SLOT_ARXV];

    // Purpose: per-pin choice between override level and data register
    always_comb begin
        pad_o  = (regs[SLOT_SEL] & atr_level) | (~regs[SLOT_SEL] & regs[SLOT_OUT]);
        pad_oe = regs[SLOT_OE];
    end

    // R6: no selected pins means the data register drives every pin
    a_r6_override_off: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[SLOT_SEL] == '0) |-> (pad_o == regs[SLOT_OUT]));

    // R7: fully selected group follows the transmit level while transmitting
    a_r7_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && (regs[SLOT_SEL] == '1)) |-> (pad_o == regs[SLOT_ATXV]));

    // R8: fully selected group follows the receive level while receiving
    a_r8_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && (regs[SLOT_SEL] == '1)) |-> (pad_o == regs[SLOT_ARXV]));
endmodule

// File: rtl/gpio_atr_bank.sv
// Module: top of the GPIO bank for one radio side. Two pin groups share
// the write port; a read strobe returns both groups' synchronised pad
// levels. Assumes pads are tristated outside this block using *_pad_oe.
module gpio_atr_bank
    import gpio_atr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tx_active,
    input  logic [GPIO_W-1:0] tx_pad_i,
    output logic [GPIO_W-1:0] tx_pad_o,
    output logic [GPIO_W-1:0] tx_pad_oe,
    input  logic [GPIO_W-1:0] rx_pad_i,
    output logic [GPIO_W-1:0] rx_pad_o,
    output logic [GPIO_W-1:0] rx_pad_oe
);
    logic [GPIO_W-1:0] tx_sync;
    logic [GPIO_W-1:0] rx_sync;
    logic              rb_hit;

    gpio_group #(
        .W(GPIO_W), .AW(ADDR_W),
        .A_OE(A_TX_OE), .A_OUT(A_TX_OUT), .A_SEL(A_TX_SEL),
        .A_ATXV(A_TX_ATXV), .A_ARXV(A_TX_ARXV)
    ) u_tx_grp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_active(tx_active),
        .pad_o(tx_pad_o), .pad_oe(tx_pad_oe)
    );

    gpio_group #(
        .W(GPIO_W), .AW(ADDR_W),
        .A_OE(A_RX_OE), .A_OUT(A_RX_OUT), .A_SEL(A_RX_SEL),
        .A_ATXV(A_RX_ATXV), .A_ARXV(A_RX_ARXV)
    ) u_rx_grp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_active(tx_active),
        .pad_o(rx_pad_o), .pad_oe(rx_pad_oe)
    );

    gpio_sync2 #(.W(GPIO_W)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .d(tx_pad_i), .q(tx_sync)
    );

    gpio_sync2 #(.W(GPIO_W)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_pad_i), .q(rx_sync)
    );

    // Purpose: decode a read of the pad readback address
    always_comb rb_hit = rd_en && (rd_addr == A_PAD_RB);

    // Purpose: capture the packed pad levels on a readback strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rb_hit)
            rd_data <= {rx_sync, tx_sync};
    end

    // R9: the readback word only moves on a readback strobe
    a_r9_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_hit && $past(rst_n)) |=> $stable(rd_data));
endmodule

// File: tb/sim_gpio_atr_bank.sv
// Bench: directed scenarios for the GPIO bank, one task per scenario.
module sim_gpio_atr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_active = 1'b0;
    logic [15:0] tx_pad_i = '0;
    logic [15:0] tx_pad_o;
    logic [15:0] tx_pad_oe;
    logic [15:0] rx_pad_i = '0;
    logic [15:0] rx_pad_o;
    logic [15:0] rx_pad_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_atr_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_active(tx_active), .tx_pad_i(tx_pad_i), .tx_pad_o(tx_pad_o),
        .tx_pad_oe(tx_pad_oe), .rx_pad_i(rx_pad_i), .rx_pad_o(rx_pad_o),
        .rx_pad_oe(rx_pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [15:0] m, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = {m, v};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_rb(output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd10;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 tx_pad_oe", {16'h0, tx_pad_oe}, 32'h0);
        check("R1 rx_pad_oe", {16'h0, rx_pad_oe}, 32'h0);
        check("R1 pad_o", {rx_pad_o, tx_pad_o}, 32'h0);
        read_rb(v);
        check("R1 readback", v, 32'h0);
    endtask

    task automatic t_masked();
        write_reg(4'd1, 16'hFFFF, 16'hA5A5);
        check("R5 tx data drives", {16'h0, tx_pad_o}, 32'h0000A5A5);
        write_reg(4'd1, 16'h00F0, 16'h0F0F);
        check("R2 partial mask", {16'h0, tx_pad_o}, 32'h0000A505);
        write_reg(4'd1, 16'h0000, 16'hFFFF);
        check("R2 zero mask keeps", {16'h0, tx_pad_o}, 32'h0000A505);
    endtask

    task automatic t_oe();
        write_reg(4'd0, 16'hFFFF, 16'h00FF);
        check("R4 tx oe", {16'h0, tx_pad_oe}, 32'h000000FF);
        check("R10 rx oe untouched", {16'h0, rx_pad_oe}, 32'h0);
        check("R10 rx out untouched", {16'h0, rx_pad_o}, 32'h0);
        write_reg(4'd2, 16'hFF00, 16'hF0F0);
        check("R4 rx oe", {16'h0, rx_pad_oe}, 32'h0000F000);
    endtask

    task automatic t_atr();
        write_reg(4'd3, 16'hFFFF, 16'h1234);
        write_reg(4'd8, 16'hFFFF, 16'h00AA);
        write_reg(4'd9, 16'hFFFF, 16'h0055);
        check("R6 rx override off", {16'h0, rx_pad_o}, 32'h00001234);
        write_reg(4'd7, 16'hFFFF, 16'h00FF);
        tx_active = 1'b1;
        #1;
        check("R7 rx group transmit level", {16'h0, rx_pad_o}, 32'h000012AA);
        tx_active = 1'b0;
        #1;
        check("R8 rx group receive level", {16'h0, rx_pad_o}, 32'h00001255);
        check("R10 tx group unaffected", {16'h0, tx_pad_o}, 32'h0000A505);
        write_reg(4'd4, 16'hFFFF, 16'h000F);
        write_reg(4'd5, 16'hFFFF, 16'h0003);
        write_reg(4'd6, 16'hFFFF, 16'h000C);
        tx_active = 1'b1;
        #1;
        check("R7 tx group transmit level", {16'h0, tx_pad_o}, 32'h0000A503);
        tx_active = 1'b0;
        #1;
        check("R8 tx group receive level", {16'h0, tx_pad_o}, 32'h0000A50C);
        write_reg(4'd7, 16'hFFFF, 16'h0000);
        tx_active = 1'b1;
        #1;
        check("R6 rx override cleared", {16'h0, rx_pad_o}, 32'h00001234);
        tx_active = 1'b0;
    endtask

    task automatic t_unmapped();
        for (int a = 11; a < 16; a++) begin
            write_reg(4'(a), 16'hFFFF, 16'hFFFF);
        end
        check("R3 unmapped tx out", {16'h0, tx_pad_o}, 32'h0000A50C);
        check("R3 unmapped rx out", {16'h0, rx_pad_o}, 32'h00001234);
        check("R3 unmapped oe", {rx_pad_oe, tx_pad_oe}, 32'hF00000FF);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        @(negedge clk);
        tx_pad_i = 16'hBEEF; rx_pad_i = 16'hCAFE;
        repeat (2) @(negedge clk);
        read_rb(v);
        check("R9 readback packing", v, 32'hCAFEBEEF);
        @(negedge clk);
        tx_pad_i = 16'h1111; rx_pad_i = 16'h2222;
        rd_en = 1'b1; rd_addr = 4'd10;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 two-stage latency", rd_data, 32'hCAFEBEEF);
        repeat (4) @(negedge clk);
        check("R9 hold without strobe", rd_data, 32'hCAFEBEEF);
        rd_en = 1'b1; rd_addr = 4'd3;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 other read address", rd_data, 32'hCAFEBEEF);
        read_rb(v);
        check("R9 new pads", v, 32'h22221111);
    endtask

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_masked();
        t_oe();
        t_atr();
        t_unmapped();
        t_readback();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule